// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Engine

A single-channel controller that walks a ring of fixed-size descriptors for a DMA engine. Software sets up the ring base address, the ring size and a tail index through a small write port. Once started, the engine issues one fetch request per descriptor slot on a valid/acknowledge handshake. It moves from the current index toward the tail, wraps to slot 0 after the last slot, and suspends when the current index meets the tail. Software hands more descriptors to the engine by moving the tail forward, which restarts the walk. No ownership bit is kept in the descriptors.

Each request also carries a burst length. The burst is either the programmed value or that value times eight. A programmable limit caps the number of fetches in flight. The current index and a suspended flag are visible at all times. A sticky error flag records any tail write that lands outside the ring.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset the current index and tail index are 0, the last-slot index is 2^IDX_W-1, the start bit is 0, the burst value is 1 with scaling off, the in-flight limit field is 1, `req_valid` is 0, `suspended` is 1 and `err` is 0.
- R2: The write port decodes `wr_sel`: 0 = base address, 1 = last-slot index (ring size minus one), 2 = tail index, 3 = control (bit 0 start, bit 1 times-eight burst, bits [BURST_W+1:2] burst value), 4 = in-flight limit field. While `req_valid` is high, `req_addr` equals base + 16 x current index. Without a write, `req_valid` and `req_addr` hold until `req_ack`.
- R3: The current index advances by one only in a cycle where `req_valid` and `req_ack` are both high. From the last-slot index it wraps to 0.
- R4: When the current index equals the tail index, `suspended` is 1 and no request is issued.
- R5: A tail write inside the ring that differs from the current index resumes fetching, up to the slot just before the tail. A tail write equal to the current index leaves the engine suspended.
- R6: A tail write whose value exceeds the last-slot index is ignored, and it sets `err`, which stays set until reset.
- R7: `req_burst` equals the burst value when the times-eight bit is 0, and the burst value times 8 when it is 1.
- R8: Accepted requests raise the in-flight count and `cmpl` pulses lower it (a pulse at count 0 is ignored). No request is issued while the count equals the limit field plus one.
- R9: With the start bit 0 no request is issued. Completions still drain the in-flight count, and setting the bit again resumes from the current index.
- R10: A write to the base address or the last-slot index resets the current and tail indices to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | DATA_W | Write data |
| req_valid | output | 1 | Descriptor fetch request |
| req_addr | output | DATA_W | Descriptor address |
| req_burst | output | BURST_W+3 | Burst length of the request |
| req_ack | input | 1 | Request accepted |
| cmpl | input | 1 | One outstanding fetch completed |
| cur_idx | output | IDX_W | Current descriptor index |
| suspended | output | 1 | Current index equals tail |
| err | output | 1 | Sticky out-of-ring tail write flag |

## Verification
The main walk is driven by a sequence of tail writes on an eight-slot ring:
- a plain advance;
- a repeat of the same tail, which must produce no fetch;
- a tail behind the current index, which forces a wrap;
- an out-of-ring tail, which must be ignored and latch the error;
- a tail that needs a full wrap.

For each write the bench compares the number of fetches, every fetch address and the final index against expected values. These separate correct ring arithmetic from off-by-one and wrap faults. Directed phases then check fetches held without acknowledge, in-flight limiting with completions withheld, stop and resume through the start bit, and the effect of the times-eight burst bit.

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int BURST_W = 6,
  parameter int OSR_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 req_valid,
  output logic [DATA_W-1:0]    req_addr,
  output logic [BURST_W+2:0]   req_burst,
  input  logic                 req_ack,
  input  logic                 cmpl,
  output logic [IDX_W-1:0]     cur_idx,
  output logic                 suspended,
  output logic                 err
);
  localparam int CNT_W  = OSR_W + 1;
  localparam int SLOT_SH = 4;

  logic [DATA_W-1:0]  base_q;
  logic [IDX_W-1:0]   last_q, tail_q, cur_q;
  logic               run_q, x8_q, err_q;
  logic [BURST_W-1:0] burst_q;
  logic [OSR_W-1:0]   osr_q;
  logic [CNT_W-1:0]   out_q;

  logic wr_ring, wr_tail, tail_ok, accept, drop;
  logic [IDX_W-1:0] cur_nxt;

  assign wr_ring = wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1);
  assign wr_tail = wr_en && wr_sel == 3'd2;
  assign tail_ok = (wr_data[DATA_W-1:IDX_W] == '0) && (wr_data[IDX_W-1:0] <= last_q);
  assign accept  = req_valid && req_ack;
  assign drop    = cmpl && (out_q != '0);
  assign cur_nxt = (cur_q == last_q) ? '0 : cur_q + 1'b1;

  assign suspended = (cur_q == tail_q);
  assign req_valid = run_q && !suspended && (out_q <= {1'b0, osr_q});
  assign req_addr  = base_q + (DATA_W'(cur_q) << SLOT_SH);
  assign req_burst = x8_q ? {burst_q, 3'b000} : {3'b000, burst_q};
  assign cur_idx   = cur_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      last_q  <= '1;
      run_q   <= 1'b0;
      x8_q    <= 1'b0;
      burst_q <= BURST_W'(1);
      osr_q   <= OSR_W'(1);
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: base_q <= wr_data;
        3'd1: last_q <= wr_data[IDX_W-1:0];
        3'd3: begin
          run_q   <= wr_data[0];
          x8_q    <= wr_data[1];
          burst_q <= wr_data[BURST_W+1:2];
        end
        3'd4: osr_q <= wr_data[OSR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_ring) begin
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (accept) cur_q <= cur_nxt;
      if (wr_tail) begin
        if (tail_ok) tail_q <= wr_data[IDX_W-1:0];
        else         err_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_q + CNT_W'(accept) - CNT_W'(drop);
  end
endmodule

// File: rtl/desc_ring_sva.sv
module desc_ring_sva #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OSR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              req_valid,
  input logic              req_ack,
  input logic [DATA_W-1:0] req_addr,
  input logic              suspended,
  input logic              err,
  input logic              run,
  input logic [IDX_W-1:0]  cur,
  input logic [IDX_W-1:0]  tail,
  input logic [IDX_W-1:0]  last,
  input logic [OSR_W-1:0]  osr,
  input logic [OSR_W:0]    outstanding
);
  logic ring_wr, bad_tail;
  assign ring_wr  = wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1);
  assign bad_tail = wr_en && wr_sel == 3'd2 &&
                    ((wr_data[DATA_W-1:IDX_W] != '0) || (wr_data[IDX_W-1:0] > last));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack && !wr_en |=> req_valid && $stable(req_addr));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && !ring_wr && cur != last |=> cur == $past(cur) + 1'b1);
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && !ring_wr && cur == last |=> cur == '0);
  a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ack) && !ring_wr |=> $stable(cur));
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !req_valid);
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    bad_tail |=> $stable(tail) && err);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= {1'b0, osr} + 1'b1);
  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !req_valid);
  a_r10_ring: assert property (@(posedge clk) disable iff (!rst_n)
    ring_wr |=> cur == '0 && tail == '0);
endmodule

bind desc_ring_engine desc_ring_sva #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OSR_W(OSR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .req_valid(req_valid), .req_ack(req_ack), .req_addr(req_addr),
  .suspended(suspended), .err(err), .run(run_q), .cur(cur_q), .tail(tail_q),
  .last(last_q), .osr(osr_q), .outstanding(out_q)
);

// File: tb/tb_desc_ring_engine.sv
module tb_desc_ring_engine;
  localparam int PER  = 10;
  localparam int BASE = 32'h0000_1000;
  localparam int LAST = 7;
  // tail to write, fetches expected, index afterwards, err afterwards
  localparam int TBL [6][4] = '{
    '{3, 3, 3, 0}, '{3, 0, 3, 0}, '{1, 6, 1, 0},
    '{9, 0, 1, 1}, '{0, 7, 0, 1}, '{5, 5, 5, 1}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, req_ack = 0, cmpl = 0;
  logic [2:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic req_valid, suspended, err;
  logic [31:0] req_addr;
  logic [8:0]  req_burst;
  logic [7:0]  cur_idx;
  int total = 0, bad = 0, exp_idx = 0, n = 0;

  desc_ring_engine dut (.*);

  always #(PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      if (req_valid && req_ack) begin
        cnt++;
        chk(req_addr == BASE + 16 * exp_idx, "R2 addr", req_addr, BASE + 16 * exp_idx);
        exp_idx = (exp_idx == LAST) ? 0 : exp_idx + 1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(PER * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 0, "R1 valid", req_valid, 0);
    chk(cur_idx == 0, "R1 cur", cur_idx, 0);
    chk(suspended == 1, "R1 susp", suspended, 1);
    chk(err == 0, "R1 err", err, 0);
    chk(req_burst == 1, "R1 burst", req_burst, 1);

    wr(0, BASE); wr(1, LAST);
    req_ack = 1; cmpl = 1;
    wr(2, 2);
    run(8, n);
    chk(n == 0, "R9 no start", n, 0);
    wr(2, 0);
    wr(3, 1 | (4 << 2));

    for (int e = 0; e < 6; e++) begin
      wr(2, TBL[e][0]);
      run(24, n);
      chk(n == TBL[e][1], "R5 fetch count", n, TBL[e][1]);
      chk(cur_idx == TBL[e][2], "R3 index", cur_idx, TBL[e][2]);
      chk(err == TBL[e][3], "R6 err", err, TBL[e][3]);
      chk(suspended == 1, "R4 susp", suspended, 1);
    end

    wr(3, 1 | 2 | (4 << 2));
    chk(req_burst == 32, "R7 x8", req_burst, 32);
    wr(3, 1 | (4 << 2));
    chk(req_burst == 4, "R7 plain", req_burst, 4);

    wr(1, LAST);
    exp_idx = 0;
    chk(cur_idx == 0, "R10 cur reset", cur_idx, 0);
    chk(suspended == 1, "R10 susp", suspended, 1);

    req_ack = 0; cmpl = 0;
    wr(2, 6);
    repeat (3) @(negedge clk);
    chk(req_valid == 1, "R2 hold valid", req_valid, 1);
    chk(req_addr == BASE, "R2 hold addr", req_addr, BASE);
    chk(cur_idx == 0, "R3 no ack", cur_idx, 0);

    req_ack = 1;
    run(10, n);
    chk(n == 2, "R8 limit default", n, 2);
    chk(cur_idx == 2, "R8 index", cur_idx, 2);
    cmpl = 1;
    @(negedge clk);
    cmpl = 0;
    run(10, n);
    chk(n == 1, "R8 one completion", n, 1);
    wr(4, 3);
    run(10, n);
    chk(n == 2, "R8 raised limit", n, 2);
    chk(cur_idx == 5, "R8 index2", cur_idx, 5);

    wr(3, (4 << 2));
    run(6, n);
    chk(n == 0, "R9 stopped", n, 0);
    cmpl = 1;
    run(8, n);
    chk(n == 0, "R9 drain no fetch", n, 0);
    chk(cur_idx == 5, "R9 index held", cur_idx, 5);
    wr(3, 1 | (4 << 2));
    run(10, n);
    chk(n == 1, "R9 resume", n, 1);
    chk(cur_idx == 6, "R9 index", cur_idx, 6);
    chk(suspended == 1, "R4 end susp", suspended, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule